// File: doc/BRIEF.md
# Prescaled Real-Time Counter

This block keeps a 32-bit time count that advances at a programmable fraction of an external real-time input rate. The input arrives in the bus clock domain as a one-cycle enable strobe. A prescaler counts accepted strobes. Each time it reaches the programmed limit it issues one tick, and that tick advances the time count by one. The divide ratio is the programmed limit plus one, so a limit of zero passes every strobe through as a tick.

Software uses a small word-addressed register bus to reach four registers:
- A control word holding the run enable.
- A write-only preset port that overwrites the time count.
- The prescale limit.
- A read-only view of the time count.

Writing the prescale limit or presetting the count restarts the prescaler phase, so the next tick comes one full period later. Clearing the enable freezes the prescaler where it stands.

A build option can place a rising-edge detector on the real-time input, so that a level clock can be fed in instead of a strobe.

Top module: `prescaled_rtc`

## Requirements
- R1: After reset the control word (0x00), the prescale limit (0x08) and the time count (0x0C) all read as zero.
- R2: With limit P at offset 0x08, the time count advances by one once for every P+1 accepted strobes. P=0 advances it on every strobe. P=0xFFFF_FFFF reads back unchanged and gives no advance within a short run of strobes.
- R3: A write to the prescale limit clears the prescaler phase, and a strobe in the same cycle as that write is discarded. The next advance comes after P+1 further strobes.
- R4: Bit 0 of the control word at 0x00 is the run enable. While it is 0, strobes neither advance the count nor move the prescaler, which keeps its partial count until the enable is set again.
- R5: A write to offset 0x04 copies the write data into the time count, visible on the cycle after the write. Reads of 0x04 return zero.
- R6: A preset through 0x04 clears the prescaler phase. If the preset falls in the same cycle as a terminal strobe, the preset value wins and no increment is applied.
- R7: The time count wraps from 0xFFFF_FFFF to 0 on an advance.
- R8: The time count register at 0x0C ignores writes. Reading it never changes the count.
- R9: Offsets that are not one of 0x00, 0x04, 0x08 or 0x0C read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rtc_in | input | 1 | Real-time input strobe (or level clock when the edge option is built) |
| bus_wr | input | 1 | Write enable for the register bus |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational from register state |

## Verification
A bus access and a prescaler terminal count can land in the same clock cycle. This applies to a preset of the count and to a rewrite of the prescale limit. The bench brings the prescaler to its terminal phase with exact strobe counts. It then drives the bus write and the strobe together in one cycle. The outcome is judged at the ports: the count must show the preset value, or stay unchanged for a limit rewrite, with no extra increment. The next advance must then need exactly P+1 more strobes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   // word index of each register (byte offset >> 2); decode depends on these
   localparam logic [1:0] IDX_CTRL   = 2'd0;
   localparam logic [1:0] IDX_PRESET = 2'd1;
   localparam logic [1:0] IDX_LIMIT  = 2'd2;
   localparam logic [1:0] IDX_COUNT  = 2'd3;

   // one-hot register write strobes
   typedef struct packed {
      logic ctrl;
      logic preset;
      logic limit;
   } rtc_wsel_t;

endpackage

// File: rtl/rtc_edge_qual.sv
module rtc_edge_qual (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic rise_stb
);

   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_in;
   end

   assign rise_stb = level_in & ~prev_q;

endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
   import rtc_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int LIM_W  = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [CNT_W-1:0]  count_val,
   output rtc_wsel_t         wsel,
   output logic              run_en,
   output logic [LIM_W-1:0]  limit_val,
   output logic [DATA_W-1:0] bus_rdata
);

   logic       in_map;
   logic [1:0] idx;

   assign idx = bus_addr[3:2];

   generate
      if (ADDR_W > 4) begin : g_upper
         assign in_map = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:4] == '0);
      end else begin : g_flat
         assign in_map = (bus_addr[1:0] == 2'b00);
      end
   endgenerate

   always_comb begin
      wsel        = '0;
      wsel.ctrl   = bus_wr && in_map && (idx == IDX_CTRL);
      wsel.preset = bus_wr && in_map && (idx == IDX_PRESET);
      wsel.limit  = bus_wr && in_map && (idx == IDX_LIMIT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_en    <= 1'b0;
         limit_val <= '0;
      end else begin
         if (wsel.ctrl)  run_en    <= bus_wdata[0];
         if (wsel.limit) limit_val <= bus_wdata[LIM_W-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_map) begin
         unique case (idx)
            IDX_CTRL:   bus_rdata[0]         = run_en;
            IDX_PRESET: bus_rdata            = '0;
            IDX_LIMIT:  bus_rdata[LIM_W-1:0] = limit_val;
            IDX_COUNT:  bus_rdata[CNT_W-1:0] = count_val;
            default:    bus_rdata            = '0;
         endcase
      end
   end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int LIM_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic             stb,
   input  logic             restart,
   input  logic [LIM_W-1:0] limit_val,
   output logic [LIM_W-1:0] phase,
   output logic             tick
);

   logic at_limit;

   assign at_limit = (phase == limit_val);
   assign tick     = run_en && stb && !restart && at_limit;

   always_ff @(posedge clk) begin
      if (!rst_n)              phase <= '0;
      else if (restart)        phase <= '0;
      else if (run_en && stb)  phase <= at_limit ? '0 : phase + 1'b1;
   end

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             preset,
   input  logic [CNT_W-1:0] preset_val,
   input  logic             tick,
   output logic [CNT_W-1:0] count
);

   always_ff @(posedge clk) begin
      if (!rst_n)      count <= '0;
      else if (preset) count <= preset_val;
      else if (tick)   count <= count + 1'b1;
   end

endmodule

// File: rtl/prescaled_rtc.sv
module prescaled_rtc
   import rtc_pkg::*;
#(
   parameter int ADDR_W      = 4,
   parameter int DATA_W      = 32,
   parameter int LIM_W       = 32,
   parameter int CNT_W       = 32,
   parameter bit EDGE_DETECT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rtc_in,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata
);

   generate
      if (ADDR_W < 4)      begin : g_bad_addr  $error("ADDR_W must be at least 4"); end
      if (LIM_W > DATA_W)  begin : g_bad_limit $error("LIM_W exceeds DATA_W");      end
      if (CNT_W > DATA_W)  begin : g_bad_count $error("CNT_W exceeds DATA_W");      end
      if (LIM_W < 1 || CNT_W < 1) begin : g_bad_w $error("widths must be positive"); end
   endgenerate

   rtc_wsel_t        wsel;
   logic             run_en;
   logic [LIM_W-1:0] limit_val;
   logic [LIM_W-1:0] phase;
   logic [CNT_W-1:0] time_cnt;
   logic             stb;
   logic             cnt_tick;
   logic             restart;

   generate
      if (EDGE_DETECT) begin : g_edge
         rtc_edge_qual u_qual (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (rtc_in),
            .rise_stb (stb)
         );
      end else begin : g_strobe
         assign stb = rtc_in;
      end
   endgenerate

   assign restart = wsel.limit | wsel.preset;

   rtc_regfile #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LIM_W  (LIM_W),
      .CNT_W  (CNT_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .count_val (time_cnt),
      .wsel      (wsel),
      .run_en    (run_en),
      .limit_val (limit_val),
      .bus_rdata (bus_rdata)
   );

   rtc_prescaler #(.LIM_W(LIM_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .stb       (stb),
      .restart   (restart),
      .limit_val (limit_val),
      .phase     (phase),
      .tick      (cnt_tick)
   );

   rtc_time_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .preset     (wsel.preset),
      .preset_val (bus_wdata[CNT_W-1:0]),
      .tick       (cnt_tick),
      .count      (time_cnt)
   );

endmodule

// File: rtl/prescaled_rtc_chk.sv
module prescaled_rtc_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int LIM_W  = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              run_en,
   input logic [LIM_W-1:0]  limit_val,
   input logic [LIM_W-1:0]  phase,
   input logic [CNT_W-1:0]  time_cnt,
   input logic              cnt_tick
);

   logic wr_preset, wr_limit, wr_count;
   assign wr_preset = bus_wr && (bus_addr == ADDR_W'(4));
   assign wr_limit  = bus_wr && (bus_addr == ADDR_W'(8));
   assign wr_count  = bus_wr && (bus_addr == ADDR_W'(12));

   // R2: the prescaler phase never runs past the limit
   assert_phase_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase <= limit_val);

   // R3: a limit write leaves the prescaler at phase zero
   assert_limit_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_limit |=> (phase == '0));

   // R4: with the enable clear and no restart, nothing moves
   assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !wr_limit && !wr_preset) |=> ($stable(phase) && $stable(time_cnt)));

   // R5: a preset shows the written data on the next cycle
   assert_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_preset |=> (time_cnt == $past(bus_wdata[CNT_W-1:0])));

   // R6: a preset restarts the prescaler phase
   assert_preset_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_preset |=> (phase == '0));

   // R7: an advance from all ones wraps to zero
   assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_tick && !wr_preset && (time_cnt == '1)) |=> (time_cnt == '0));

   // R8: writes to the count register do not move the count
   assert_count_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_count && !cnt_tick) |=> $stable(time_cnt));

endmodule

bind prescaled_rtc prescaled_rtc_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .LIM_W  (LIM_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .run_en    (run_en),
   .limit_val (limit_val),
   .phase     (phase),
   .time_cnt  (time_cnt),
   .cnt_tick  (cnt_tick)
);

// File: tb/prescaled_rtc_tb.sv
`timescale 1ns/1ps
module prescaled_rtc_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rtc_in = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   prescaled_rtc u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .rtc_in    (rtc_in),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_with_strobe(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; rtc_in = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; rtc_in = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rtc_in = 1'b1;
         @(negedge clk); rtc_in = 1'b0;
      end
   endtask

   task automatic setup(input logic [31:0] lim, input logic [31:0] start, input logic en);
      wr(4'h8, lim);
      wr(4'h0, {31'b0, en});
      wr(4'h4, start);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      rd(4'h0, v); check("R1 ctrl", v, 32'h0);
      rd(4'h8, v); check("R1 limit", v, 32'h0);
      rd(4'hC, v); check("R1 count", v, 32'h0);
   endtask

   task automatic t_ratio;
      logic [31:0] v;
      setup(32'd0, 32'd0, 1'b1);
      strobes(5);  rd(4'hC, v); check("R2 limit0", v, 32'd5);
      wr(4'h8, 32'd3);
      strobes(7);  rd(4'hC, v); check("R2 limit3 7 strobes", v, 32'd6);
      strobes(1);  rd(4'hC, v); check("R2 limit3 8 strobes", v, 32'd7);
      repeat (10) @(negedge clk);
      rd(4'hC, v); check("R2 idle", v, 32'd7);
   endtask

   task automatic t_freeze;
      logic [31:0] v;
      setup(32'd3, 32'd0, 1'b1);
      strobes(2);
      wr(4'h0, 32'd0);
      rd(4'h0, v); check("R4 ctrl clear", v, 32'd0);
      strobes(10); rd(4'hC, v); check("R4 frozen", v, 32'd0);
      wr(4'h0, 32'd1);
      strobes(1);  rd(4'hC, v); check("R4 phase held a", v, 32'd0);
      strobes(1);  rd(4'hC, v); check("R4 phase held b", v, 32'd1);
   endtask

   task automatic t_limit_restart;
      logic [31:0] v;
      setup(32'd3, 32'd0, 1'b1);
      strobes(2);
      wr(4'h8, 32'd3);
      strobes(3);  rd(4'hC, v); check("R3 no early tick", v, 32'd0);
      strobes(1);  rd(4'hC, v); check("R3 full period", v, 32'd1);
      strobes(3);
      wr_with_strobe(4'h8, 32'd3);
      rd(4'hC, v); check("R3 collision strobe dropped", v, 32'd1);
      strobes(3);  rd(4'hC, v); check("R3 after collision a", v, 32'd1);
      strobes(1);  rd(4'hC, v); check("R3 after collision b", v, 32'd2);
   endtask

   task automatic t_preset;
      logic [31:0] v;
      setup(32'd3, 32'h1234, 1'b1);
      rd(4'hC, v); check("R5 preset value", v, 32'h1234);
      rd(4'h4, v); check("R5 preset reads zero", v, 32'h0);
      strobes(2);
      wr(4'h4, 32'h2000);
      strobes(3);  rd(4'hC, v); check("R6 restart a", v, 32'h2000);
      strobes(1);  rd(4'hC, v); check("R6 restart b", v, 32'h2001);
      strobes(3);
      wr_with_strobe(4'h4, 32'h50);
      rd(4'hC, v); check("R6 preset wins", v, 32'h50);
      strobes(3);  rd(4'hC, v); check("R6 after collision a", v, 32'h50);
      strobes(1);  rd(4'hC, v); check("R6 after collision b", v, 32'h51);
   endtask

   task automatic t_wrap;
      logic [31:0] v;
      setup(32'd0, 32'hFFFF_FFFF, 1'b1);
      strobes(1);  rd(4'hC, v); check("R7 wrap", v, 32'h0);
      strobes(1);  rd(4'hC, v); check("R7 after wrap", v, 32'h1);
   endtask

   task automatic t_readonly;
      logic [31:0] v;
      setup(32'd0, 32'h77, 1'b0);
      wr(4'hC, 32'hDEAD_BEEF);
      rd(4'hC, v); check("R8 write ignored", v, 32'h77);
      rd(4'hC, v); check("R8 read stable", v, 32'h77);
   endtask

   task automatic t_unmapped;
      logic [31:0] v;
      setup(32'd5, 32'h99, 1'b1);
      rd(4'h2, v); check("R9 read 0x2", v, 32'h0);
      rd(4'h7, v); check("R9 read 0x7", v, 32'h0);
      wr(4'h1, 32'h0);
      wr(4'h9, 32'hFF);
      wr(4'h5, 32'h1);
      rd(4'h0, v); check("R9 ctrl kept", v, 32'h1);
      rd(4'h8, v); check("R9 limit kept", v, 32'h5);
      rd(4'hC, v); check("R9 count kept", v, 32'h99);
   endtask

   task automatic t_max_limit;
      logic [31:0] v;
      setup(32'hFFFF_FFFF, 32'd0, 1'b1);
      rd(4'h8, v); check("R2 max limit readback", v, 32'hFFFF_FFFF);
      strobes(20); rd(4'hC, v); check("R2 max limit no tick", v, 32'd0);
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ratio();
      t_freeze();
      t_limit_restart();
      t_preset();
      t_wrap();
      t_readonly();
      t_unmapped();
      t_max_limit();
      finish_run();
   end

endmodule